// File: doc/BRIEF.md
# Store Queue with Read-Miss Bypass

This block sits between a data cache and a slow, single-channel memory port. The cache hands it stores, or the words of an evicted dirty block, and the block keeps them in an ordered queue. An internal drain engine sends them to memory on its own, oldest first. Stores can keep arriving while memory is busy, up to the queue depth. When the queue is full, new stores are stalled.

A read miss does not have to wait for the queue to empty. Its address is compared at line granularity against every occupied queue slot. If no slot matches, the read takes the memory port ahead of all queued stores. If a slot matches, the read is held back while the queue drains. The read is released as soon as no matching slot is left, so stores queued behind the youngest match are still written after the read.

To evict a dirty block, the cache first pushes the victim words and then raises the read. The read then bypasses the victim data, and the victim data reaches memory afterwards.

Top module: `wbuf_bypass_top`

## Requirements
- R1: After reset the queue is empty: `buf_empty`=1, `buf_full`=0, `wr_ready`=1 and `mem_req_valid`=0.
- R2: A store is accepted in a cycle where `wr_valid` and `wr_ready` are both high. Accepted stores reach memory as writes (`mem_req_write`=1) in acceptance order, with address, data and byte enables unchanged. One store leaves per accepted memory handshake.
- R3: The queue holds `DEPTH` entries (default 4). While it holds `DEPTH` entries and no drain is accepted in the cycle, `buf_full`=1 and `wr_ready`=0. A store offered then is held off and is not lost.
- R4: In the cycle memory accepts a drain from a full queue, `buf_full` is already 0 and `wr_ready` is 1. A store offered in that cycle is accepted.
- R5: A read miss whose line (address bits from `LINE_LSB` upward, default bit 4) matches no occupied slot is presented on the memory port (`mem_req_write`=0, address = `rd_addr`) in the cycle it is requested. This holds even when stores are queued, and the read wins over a drain in the same cycle.
- R6: A read miss whose line matches an occupied slot is not issued while any match remains. Queued stores drain in order, and the read issues in the cycle after the youngest matching store is accepted. Stores queued behind that store are still pending when the read issues.
- R7: At most one read is outstanding. The memory response (`mem_resp_valid`, `mem_resp_data`) is forwarded unchanged on `rd_resp_valid` and `rd_resp_data`. No new read is issued before the response of the previous one has arrived.
- R8: A store accepted in the same cycle as a read issues is ordered after that read and does not block it, even if it is to the same line.
- R9: `buf_empty` is 1 exactly when no store is queued, and no memory write is presented while it is 1.
- R10: A drain write that memory does not accept stays on the port with the same address and data in the next cycle, unless a read takes the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store offered |
| wr_ready | output | 1 | Store can be accepted this cycle |
| wr_addr | input | AW | Store byte address |
| wr_data | input | DW | Store data |
| wr_be | input | DW/8 | Store byte enables |
| rd_valid | input | 1 | Read miss requested |
| rd_ready | output | 1 | Read miss issued to memory this cycle |
| rd_addr | input | AW | Read miss address |
| rd_resp_valid | output | 1 | Read data returning |
| rd_resp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write (drain), 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Write data |
| mem_req_be | output | DW/8 | Write byte enables (all ones for reads) |
| mem_resp_valid | input | 1 | Memory read response |
| mem_resp_data | input | DW | Memory read data |
| buf_full | output | 1 | Queue full |
| buf_empty | output | 1 | Queue empty |

## Verification
Each symptom below appears within a few cycles of the event that causes it.

- A corrupted head or tail pointer shows up at the next memory write handshake: a store comes out of order or with the wrong data.
- A miscounted occupancy shows up in the full and empty flags on the very next cycle. It also shows up as a store that is accepted but never drained.
- A wrong slot-valid decode or line compare shows up in the cycle the read is issued, as a read that overtakes a pending store to its own line, or as a read that waits when it had nothing to wait for.
- A stuck read-busy flag shows up as either a second read before the response arrives, or a read that is never issued.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // owner of the memory port in a cycle
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_DRAIN = 2'd2
    } port_sel_e;

endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BEW   = DW / 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [AW-1:0]            push_addr,
    input  logic [DW-1:0]            push_data,
    input  logic [BEW-1:0]           push_be,
    input  logic                     pop,
    output logic [AW-1:0]            head_addr,
    output logic [DW-1:0]            head_data,
    output logic [BEW-1:0]           head_be,
    output logic [DEPTH-1:0][AW-1:0] slot_addr,
    output logic [DEPTH-1:0]         slot_vld,
    output logic [CW-1:0]            count
);

    typedef struct packed {
        logic [PW-1:0]             head;
        logic [PW-1:0]             tail;
        logic [CW-1:0]             count;
        logic [DEPTH-1:0][AW-1:0]  addr;
        logic [DEPTH-1:0][DW-1:0]  data;
        logic [DEPTH-1:0][BEW-1:0] be;
    } q_state_t;

    q_state_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.addr[st_q.tail] = push_addr;
            st_d.data[st_q.tail] = push_data;
            st_d.be[st_q.tail]   = push_be;
            st_d.tail            = ptr_next(st_q.tail);
        end
        if (pop) begin
            st_d.head = ptr_next(st_q.head);
        end
        st_d.count = st_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a physical slot is occupied when its distance from head is below count
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int offs;
            offs        = (i + DEPTH - int'(st_q.head)) % DEPTH;
            slot_vld[i] = (offs < int'(st_q.count));
        end
    end

    assign slot_addr = st_q.addr;
    assign head_addr = st_q.addr[st_q.head];
    assign head_data = st_q.data[st_q.head];
    assign head_be   = st_q.be[st_q.head];
    assign count     = st_q.count;

    // R3: a push without a pop never lands on a full queue
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.count < CW'(DEPTH)));

    // R2: a drain only takes an entry that exists
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int DEPTH    = 4,
    parameter int AW       = 32,
    parameter int LINE_LSB = 4
) (
    input  logic [AW-1:0]            probe_addr,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0]         slot_vld,
    output logic                     hit
);

    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = slot_vld[g] &&
            (slot_addr[g][AW-1:LINE_LSB] == probe_addr[AW-1:LINE_LSB]);
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic      rd_req,
    input  logic      drain_req,
    input  logic      mem_ready,
    output port_sel_e sel,
    output logic      rd_fire,
    output logic      drain_fire
);

    always_comb begin
        sel = PORT_IDLE;
        if (rd_req)         sel = PORT_READ;
        else if (drain_req) sel = PORT_DRAIN;
    end

    assign rd_fire    = (sel == PORT_READ)  && mem_ready;
    assign drain_fire = (sel == PORT_DRAIN) && mem_ready;

endmodule

// File: rtl/wbuf_bypass_top.sv
module wbuf_bypass_top
    import wbuf_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int LINE_LSB = 4,
    localparam int BEW     = DW / 8,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [BEW-1:0] wr_be,
    input  logic           rd_valid,
    output logic           rd_ready,
    input  logic [AW-1:0]  rd_addr,
    output logic           rd_resp_valid,
    output logic [DW-1:0]  rd_resp_data,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic           mem_req_write,
    output logic [AW-1:0]  mem_req_addr,
    output logic [DW-1:0]  mem_req_data,
    output logic [BEW-1:0] mem_req_be,
    input  logic           mem_resp_valid,
    input  logic [DW-1:0]  mem_resp_data,
    output logic           buf_full,
    output logic           buf_empty
);

    typedef struct packed {
        logic rd_busy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                     push;
    logic                     drain_fire;
    logic                     rd_fire;
    logic                     rd_req;
    logic                     hit;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [BEW-1:0]           head_be;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0]         slot_vld;
    logic [CW-1:0]            count;
    port_sel_e                sel;

    wbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BEW(BEW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .push_be   (wr_be),
        .pop       (drain_fire),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_be   (head_be),
        .slot_addr (slot_addr),
        .slot_vld  (slot_vld),
        .count     (count)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .LINE_LSB(LINE_LSB)) u_match (
        .probe_addr (rd_addr),
        .slot_addr  (slot_addr),
        .slot_vld   (slot_vld),
        .hit        (hit)
    );

    wbuf_arb u_arb (
        .rd_req     (rd_req),
        .drain_req  (!buf_empty),
        .mem_ready  (mem_req_ready),
        .sel        (sel),
        .rd_fire    (rd_fire),
        .drain_fire (drain_fire)
    );

    assign rd_req    = rd_valid && !hit && !ctl_q.rd_busy;
    assign buf_empty = (count == '0);
    assign buf_full  = (count == CW'(DEPTH)) && !drain_fire;
    assign wr_ready  = !buf_full;
    assign push      = wr_valid && wr_ready;
    assign rd_ready  = rd_fire;

    assign mem_req_valid = (sel != PORT_IDLE);
    assign mem_req_write = (sel == PORT_DRAIN);
    assign mem_req_addr  = (sel == PORT_READ) ? rd_addr : head_addr;
    assign mem_req_data  = head_data;
    assign mem_req_be    = (sel == PORT_READ) ? {BEW{1'b1}} : head_be;

    assign rd_resp_valid = mem_resp_valid;
    assign rd_resp_data  = mem_resp_data;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rd_busy = (ctl_q.rd_busy && !mem_resp_valid) || rd_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R5: an eligible read never loses the port to a drain
    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !(mem_req_valid && mem_req_write));

    // R6: a read on the port never overlaps a queued store to its line
    a_r6_no_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !hit);

    // R7: only one read in flight
    a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.rd_busy |-> !(mem_req_valid && !mem_req_write));

    // R9: nothing is written to memory from an empty queue
    a_r9_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !(mem_req_valid && mem_req_write));

    // R10: a refused drain stays put unless a read takes over
    a_r10_hold_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && !mem_req_ready) |=>
        ((mem_req_valid && !mem_req_write) ||
         ($stable(mem_req_addr) && $stable(mem_req_data) && mem_req_write)));

endmodule

// File: tb/wbuf_bypass_top_tb_top.sv
module wbuf_bypass_top_tb_top;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int BEW = DW / 8;

    typedef struct {
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BEW-1:0] be;
    } st_item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_valid = 1'b0;
    logic           wr_ready;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [BEW-1:0] wr_be = '0;
    logic           rd_valid = 1'b0;
    logic           rd_ready;
    logic [AW-1:0]  rd_addr = '0;
    logic           rd_resp_valid;
    logic [DW-1:0]  rd_resp_data;
    logic           mem_req_valid;
    logic           mem_req_ready = 1'b0;
    logic           mem_req_write;
    logic [AW-1:0]  mem_req_addr;
    logic [DW-1:0]  mem_req_data;
    logic [BEW-1:0] mem_req_be;
    logic           mem_resp_valid = 1'b0;
    logic [DW-1:0]  mem_resp_data = '0;
    logic           buf_full;
    logic           buf_empty;

    int errors = 0;
    int checks = 0;
    int drain_cnt = 0;
    int resp_timer = 0;
    logic rd_inflight = 1'b0;
    logic [AW-1:0] resp_addr = '0;
    st_item_t exp_wq[$];
    logic [DW-1:0] exp_rq[$];

    always #2 clk = ~clk;

    wbuf_bypass_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .buf_full(buf_full), .buf_empty(buf_empty)
    );

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_resp_valid) begin
                rd_inflight = 1'b0;
                if (exp_rq.size() == 0) chk("R7", "unexpected read data", 1, 0);
                else chk("R7", "read data", rd_resp_data, exp_rq.pop_front());
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    drain_cnt++;
                    if (exp_wq.size() == 0) chk("R2", "unexpected drain", 1, 0);
                    else begin
                        st_item_t it;
                        it = exp_wq.pop_front();
                        chk("R2", "drain addr", mem_req_addr, it.addr);
                        chk("R2", "drain data", mem_req_data, it.data);
                        chk("R2", "drain be", mem_req_be, it.be);
                    end
                end else begin
                    chk("R7", "read while one in flight", rd_inflight, 0);
                    foreach (exp_wq[k])
                        if (exp_wq[k].addr[AW-1:4] == mem_req_addr[AW-1:4])
                            chk("R6", "read overtook same-line store", 1, 0);
                    rd_inflight = 1'b1;
                    resp_addr = mem_req_addr;
                    exp_rq.push_back(mem_val(mem_req_addr));
                end
            end
        end
        mem_resp_valid = (resp_timer == 1);
        mem_resp_data  = (resp_timer == 1) ? mem_val(resp_addr) : '0;
        if (resp_timer > 0) resp_timer--;
        if (rst_n && mem_req_valid && mem_req_ready && !mem_req_write) resp_timer = 2;
    end

    task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BEW-1:0] b);
        st_item_t it;
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = b;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
        end
        @(posedge clk); #1;
        wr_valid = 1'b0;
        it.addr = a; it.data = d; it.be = b;
        exp_wq.push_back(it);
    endtask

    task automatic wait_empty();
        forever begin
            @(negedge clk);
            if (buf_empty && !rd_inflight && exp_rq.size() == 0) break;
        end
    endtask

    task automatic set_rdy(input logic v);
        @(posedge clk); #1;
        mem_req_ready = v;
    endtask

    initial begin
        int base;
        int pend;
        logic [AW-1:0] a0;
        logic [DW-1:0] d0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "empty after reset", buf_empty, 1);
        chk("R1", "full after reset", buf_full, 0);
        chk("R1", "wr_ready after reset", wr_ready, 1);
        chk("R1", "mem_req_valid after reset", mem_req_valid, 0);

        // free-flowing stores
        set_rdy(1'b1);
        for (int i = 0; i < 6; i++)
            push_wr(32'h1000 + 32'(i * 4), 32'hA000 + 32'(i), 4'(i + 1));
        wait_empty();
        chk("R2", "all stores drained", exp_wq.size(), 0);
        chk("R9", "empty after drain", buf_empty, 1);

        // fill against a stalled memory
        set_rdy(1'b0);
        for (int i = 0; i < 4; i++)
            push_wr(32'h2000 + 32'(i * 16), 32'hB000 + 32'(i), 4'hF);
        @(negedge clk);
        chk("R3", "full at depth", buf_full, 1);
        chk("R3", "wr_ready low at depth", wr_ready, 0);
        chk("R9", "not empty when full", buf_empty, 0);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 32'h2400; wr_data = 32'hB555; wr_be = 4'h3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3", "store held off", wr_ready, 0);
        end
        a0 = mem_req_addr; d0 = mem_req_data;
        @(negedge clk);
        chk("R10", "refused drain addr held", mem_req_addr, a0);
        chk("R10", "refused drain data held", mem_req_data, d0);
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        @(negedge clk);
        chk("R4", "full drops with drain", buf_full, 0);
        chk("R4", "wr_ready with drain", wr_ready, 1);
        @(posedge clk); #1;
        wr_valid = 1'b0;
        begin
            st_item_t it;
            it.addr = 32'h2400; it.data = 32'hB555; it.be = 4'h3;
            exp_wq.push_back(it);
        end
        wait_empty();
        chk("R3", "stalled store not lost", exp_wq.size(), 0);

        // bypass of unrelated stores
        set_rdy(1'b0);
        for (int i = 0; i < 3; i++)
            push_wr(32'h3000 + 32'(i * 16), 32'hC000 + 32'(i), 4'hF);
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = 32'h9008;
        @(negedge clk);
        chk("R5", "read presented", mem_req_valid, 1);
        chk("R5", "read not write", mem_req_write, 0);
        chk("R5", "read addr", mem_req_addr, 32'h9008);
        base = drain_cnt;
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        @(negedge clk);
        chk("R5", "read issued", rd_ready, 1);
        chk("R5", "no drain before read", drain_cnt - base, 0);
        chk("R5", "stores still queued", exp_wq.size(), 3);
        @(posedge clk); #1;
        rd_valid = 1'b0;
        wait_empty();

        // hazard: read to a queued line
        set_rdy(1'b0);
        push_wr(32'h4100, 32'hD001, 4'hF);
        push_wr(32'h4200, 32'hD002, 4'hF);
        push_wr(32'h4104, 32'hD003, 4'hF);
        push_wr(32'h4300, 32'hD004, 4'hF);
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = 32'h4108;
        @(negedge clk);
        chk("R6", "read held, drain shown", mem_req_write, 1);
        chk("R6", "read not ready", rd_ready, 0);
        base = drain_cnt;
        @(posedge clk); #1;
        mem_req_ready = 1'b1;
        pend = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_ready) begin pend = exp_wq.size(); break; end
        end
        chk("R6", "drains before read", drain_cnt - base, 3);
        chk("R6", "younger store still pending", pend, 1);
        @(posedge clk); #1;
        rd_valid = 1'b0;
        wait_empty();

        // one read in flight
        @(posedge clk); #1;
        rd_valid = 1'b1; rd_addr = 32'h5000;
        @(negedge clk);
        chk("R7", "first read issued", rd_ready, 1);
        @(posedge clk); #1;
        rd_addr = 32'h5010;
        @(negedge clk);
        chk("R7", "second read waits", rd_ready, 0);
        pend = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_ready) begin pend = 1; break; end
        end
        chk("R7", "second read issued after response", pend, 1);
        @(posedge clk); #1;
        rd_valid = 1'b0;
        wait_empty();

        // same-cycle store and read to one line
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 32'h6000; wr_data = 32'hE001; wr_be = 4'hF;
        rd_valid = 1'b1; rd_addr = 32'h6004;
        @(negedge clk);
        chk("R8", "read issues with same-cycle store", rd_ready, 1);
        chk("R8", "store accepted", wr_ready, 1);
        @(posedge clk); #1;
        wr_valid = 1'b0; rd_valid = 1'b0;
        begin
            st_item_t it;
            it.addr = 32'h6000; it.data = 32'hE001; it.be = 4'hF;
            exp_wq.push_back(it);
        end
        @(negedge clk);
        chk("R9", "not empty after store", buf_empty, 0);
        wait_empty();
        chk("R8", "store drained after read", exp_wq.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule